// File: doc/BRIEF.md
# GPIO Bank with Pin Interrupts

A bank of general-purpose pins, each governed by one control word on a simple register bus (address, write strobe, write data, combinational read data). A pin is an input or an output, may request a pull resistor in either direction, and can flag an interrupt on a rising edge, a falling edge, both edges, a high level or a low level. The trigger is chosen by three independent control bits: a high-sense bit, a low-sense bit and an edge-select bit.

Two more bank-wide words sit above the pin words. The first is a read-only view of every pin's pending flag. The second is a pad-enable mask that hands each pin to GPIO use. Pending flags are sticky and are cleared by writing 1. The single bank interrupt output is a registered OR of the pending flags whose pin has its interrupt enabled.

Several control writes have side effects. Changing the trigger turns the pin into an input and drops its pending flag. Changing the interrupt enable drops the pending flag. Turning the output on drops the interrupt enable.

Top module: `gpb_bank`

## Requirements
- R1: After reset every pin word, the pending view, the pad-enable mask, `irq`, `pad_oe`, `pull_en` and `pull_up` are all zero.
- R2: Addresses 0..N_PINS-1 select the pin words, N_PINS the pending view, and N_PINS+1 the read/write pad-enable mask. Pin-word bit 1 (data-in, read-only) shows the pad value after a two-flop synchroniser, whatever the pin's direction.
- R3: Pin-word bit 0 (data-out) drives `pad_out`. Bit 2 (output enable) drives `pad_oe` while the pin's pad-enable bit is set. A write that raises bit 2 from 0 to 1 without changing the trigger leaves bit 3 (interrupt enable) at 0.
- R4: Bit 8 (pull enable) drives `pull_en`. Bit 9 (pull direction, 1 = up, 0 = down) drives `pull_up`.
- R5: Edge triggers (bit 7 = 1): bit 5 alone flags rising edges, bit 6 alone flags falling edges, and both together flag either edge. An edge of the unselected polarity sets nothing.
- R6: Level triggers (bit 7 = 0): bit 5 flags a high level and bit 6 flags a low level. The pending flag is set again on every cycle the level persists, even right after it is cleared.
- R7: The pending flag (bit 4, mirrored in the pending view at the pin's index) stays set until a write of 1 to bit 4 of the pin word clears it. Writes to the pending view have no effect.
- R8: A write that changes bits 7:5 clears the pin's output enable and its pending flag.
- R9: A write that changes bit 3 (masking or unmasking) clears the pin's pending flag.
- R10: `irq` is set one cycle after any pin has both its pending flag and its interrupt enable set, and is low otherwise. A pending flag on a masked pin does not raise `irq`.
- R11: A pin whose pad-enable bit is clear detects no events and does not drive `pad_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` |
| pad_in | input | N_PINS | Raw pad levels |
| pad_out | output | N_PINS | Output levels |
| pad_oe | output | N_PINS | Output drive enables |
| pull_en | output | N_PINS | Pull resistor enables |
| pull_up | output | N_PINS | Pull direction, 1 = up |
| irq | output | 1 | Bank interrupt |

## Verification
Each trigger setting is driven with a rising and a falling pad transition, which shows that an edge mode reacts only to its own polarity and that the both-edge mode reacts to either. Level modes are held active across a write-1-to-clear, which separates re-assertion from edge stickiness. Masking, unmasking and trigger rewrites are issued while a flag is pending, so their clearing side effects are told apart from a plain clear. Pins that are pending but masked, and pins whose pad is disabled, show that the interrupt gating and the pad-enable gating each work on their own.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int B_DOUT = 0;
  localparam int B_DIN  = 1;
  localparam int B_OE   = 2;
  localparam int B_IE   = 3;
  localparam int B_STS  = 4;
  localparam int B_HI   = 5;
  localparam int B_LO   = 6;
  localparam int B_EDGE = 7;
  localparam int B_PEN  = 8;
  localparam int B_PUP  = 9;

  typedef struct packed {
    logic pup;
    logic pen;
    logic edge_m;
    logic lo;
    logic hi;
    logic sts;
    logic ie;
    logic oe;
    logic dout;
  } pin_cfg_t;

  // trigger evaluation: cur is the synchronised level, prv the level one cycle earlier
  function automatic logic trig_hit(logic hi, logic lo, logic edge_m, logic cur, logic prv);
    if (edge_m) return (hi & cur & ~prv) | (lo & ~cur & prv);
    else        return (hi & cur) | (lo & ~cur);
  endfunction
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prv
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      cur  <= '0;
      prv  <= '0;
    end else begin
      meta <= raw;
      cur  <= meta;
      prv  <= cur;
    end
  end
endmodule

// File: rtl/gpb_pin.sv
module gpb_pin
  import gpb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          pad_en,
  input  logic          cur,
  input  logic          prv,
  output pin_cfg_t      cfg,
  output logic          hit
);
  pin_cfg_t q;
  logic trig_chg, ie_chg, oe_rise, w1c;

  assign trig_chg = wr_en && ({wdata[B_HI], wdata[B_LO], wdata[B_EDGE]} != {q.hi, q.lo, q.edge_m});
  assign ie_chg   = wr_en && (wdata[B_IE] != q.ie);
  assign oe_rise  = wr_en && !trig_chg && wdata[B_OE] && !q.oe;
  assign w1c      = wr_en && wdata[B_STS];
  assign hit      = pad_en && trig_hit(q.hi, q.lo, q.edge_m, cur, prv);
  assign cfg      = q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      if (wr_en) begin
        q.dout   <= wdata[B_DOUT];
        q.oe     <= trig_chg ? 1'b0 : wdata[B_OE];
        q.ie     <= oe_rise ? 1'b0 : wdata[B_IE];
        q.hi     <= wdata[B_HI];
        q.lo     <= wdata[B_LO];
        q.edge_m <= wdata[B_EDGE];
        q.pen    <= wdata[B_PEN];
        q.pup    <= wdata[B_PUP];
      end
      if (trig_chg || ie_chg || w1c) q.sts <= 1'b0;
      else if (hit)                  q.sts <= 1'b1;
    end
  end

  // R8
  trig_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_chg |=> (!q.oe && !q.sts));
  // R9
  ie_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ie_chg |=> !q.sts);
  // R3
  oe_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_rise |=> (q.oe && !q.ie));
  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q.sts && !wr_en) |=> q.sts);
  // R11
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pad_en && !wr_en && !q.sts) |=> !q.sts);
endmodule

// File: rtl/gpb_bank.sv
module gpb_bank
  import gpb_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter int DW     = 32,
  localparam int AW    = $clog2(N_PINS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [N_PINS-1:0] pad_in,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe,
  output logic [N_PINS-1:0] pull_en,
  output logic [N_PINS-1:0] pull_up,
  output logic              irq
);
  localparam int STS_ADDR = N_PINS;
  localparam int PEN_ADDR = N_PINS + 1;

  logic [N_PINS-1:0] cur, prv, pad_en_q, sts_v, ie_v, hit_v;
  logic [DW-1:0]     ctrl_w [N_PINS];
  logic              irq_next;

  gpb_sync #(.W(N_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pad_in), .cur(cur), .prv(prv)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    pin_cfg_t cfg;
    logic     sel;
    assign sel = bus_we && (int'(bus_addr) == i);
    gpb_pin #(.DW(DW)) u_pin (
      .clk(clk), .rst_n(rst_n), .wr_en(sel), .wdata(bus_wdata),
      .pad_en(pad_en_q[i]), .cur(cur[i]), .prv(prv[i]),
      .cfg(cfg), .hit(hit_v[i])
    );
    always_comb begin
      ctrl_w[i]         = '0;
      ctrl_w[i][B_DOUT] = cfg.dout;
      ctrl_w[i][B_DIN]  = cur[i];
      ctrl_w[i][B_OE]   = cfg.oe;
      ctrl_w[i][B_IE]   = cfg.ie;
      ctrl_w[i][B_STS]  = cfg.sts;
      ctrl_w[i][B_HI]   = cfg.hi;
      ctrl_w[i][B_LO]   = cfg.lo;
      ctrl_w[i][B_EDGE] = cfg.edge_m;
      ctrl_w[i][B_PEN]  = cfg.pen;
      ctrl_w[i][B_PUP]  = cfg.pup;
    end
    assign sts_v[i]   = cfg.sts;
    assign ie_v[i]    = cfg.ie;
    assign pad_out[i] = cfg.dout;
    assign pad_oe[i]  = cfg.oe & pad_en_q[i];
    assign pull_en[i] = cfg.pen;
    assign pull_up[i] = cfg.pup;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pad_en_q <= '0;
    else if (bus_we && int'(bus_addr) == PEN_ADDR) pad_en_q <= bus_wdata[N_PINS-1:0];
  end

  assign irq_next = |(sts_v & ie_v);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_next;
  end

  always_comb begin
    bus_rdata = '0;
    if (int'(bus_addr) < N_PINS)        bus_rdata = ctrl_w[int'(bus_addr)];
    else if (int'(bus_addr) == STS_ADDR) bus_rdata[N_PINS-1:0] = sts_v;
    else if (int'(bus_addr) == PEN_ADDR) bus_rdata[N_PINS-1:0] = pad_en_q;
  end

  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts_v & ie_v)) |=> irq);
  // R10
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(sts_v & ie_v)) |=> !irq);
  // R11
  pad_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pad_en_q[0]) |-> !pad_oe[0]);
endmodule

// File: tb/test_gpb_bank.sv
module test_gpb_bank;
  localparam int CLK_P = 10;
  localparam int N  = 8;
  localparam int DW = 32;
  localparam int AW = $clog2(N + 2);

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_we = 0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] pad_in = '0, pad_out, pad_oe, pull_en, pull_up;
  logic irq;

  always #(CLK_P/2) clk = ~clk;

  gpb_bank #(.N_PINS(N), .DW(DW)) i_gpb_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pull_en(pull_en),
    .pull_up(pull_up), .irq(irq)
  );

  typedef struct {
    int          sel;
    logic [31:0] exp;
    logic [31:0] mask;
    string       tag;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  // monitor: compares each queued expectation a quarter period after it is queued
  initial begin
    forever begin
      wait (q.size() != 0);
      #(CLK_P/4);
      begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.sel)
          0: act = bus_rdata;
          1: act = {31'd0, irq};
          2: act = 32'(pad_out);
          3: act = 32'(pad_oe);
          4: act = 32'(pull_en);
          default: act = 32'(pull_up);
        endcase
        total++;
        if ((act & it.mask) !== (it.exp & it.mask)) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act & it.mask, it.exp & it.mask);
        end
      end
    end
  end

  task automatic chk(input int sel, input int a, input logic [31:0] e, input logic [31:0] m, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = AW'(a);
    it.sel = sel; it.exp = e; it.mask = m; it.tag = tag;
    q.push_back(it);
    #(CLK_P/2 - 1);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pad(input int i, input logic v);
    @(negedge clk);
    pad_in[i] = v;
  endtask

  localparam int STS = N, PEN = N + 1;

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    pad_in[7] = 1;
    cyc(3); rst_n = 1;
    // R1 reset state
    chk(0, 0, 32'h0, 32'hFFFFFFFF, "R1 pin0 word");
    chk(0, STS, 0, 32'hFF, "R1 pending view");
    chk(0, PEN, 0, 32'hFF, "R1 pad enable");
    chk(1, 0, 0, 1, "R1 irq");
    chk(3, 0, 0, 32'hFF, "R1 pad_oe");
    // R2 pad-enable register
    wr(PEN, 32'hFF);
    chk(0, PEN, 32'hFF, 32'hFF, "R2 pad enable readback");
    // R4 pulls
    wr(1, 32'h300); wr(2, 32'h100);
    chk(4, 0, 32'h06, 32'h06, "R4 pull_en");
    chk(5, 0, 32'h02, 32'h06, "R4 pull_up");
    // R3 output enable drops interrupt enable
    wr(0, 32'h8); wr(0, 32'hD);
    chk(0, 0, 32'h5, 32'h3FF, "R3 pin0 word after output on");
    chk(3, 0, 1, 1, "R3 pad_oe");
    chk(2, 0, 1, 1, "R3 pad_out");
    // R2 data-in
    pad(3, 1); cyc(3);
    chk(0, 3, 32'h2, 32'h2, "R2 din input pin");
    pad(0, 1); cyc(3);
    chk(0, 0, 32'h2, 32'h2, "R2 din output pin");
    pad(0, 0); pad(3, 0); cyc(3);
    // R5 rising
    wr(3, 32'hA8); cyc(2);
    pad(3, 1); cyc(5);
    chk(0, STS, 32'h08, 32'h08, "R5 rising sets");
    chk(1, 0, 1, 1, "R10 irq high");
    wr(3, 32'hB8);
    chk(0, STS, 0, 32'h08, "R7 w1c clears");
    cyc(2);
    chk(1, 0, 0, 1, "R10 irq low");
    pad(3, 0); cyc(5);
    chk(0, STS, 0, 32'h08, "R5 falling ignored in rising mode");
    // R5 falling, R7 sticky
    pad(4, 1); cyc(4);
    wr(4, 32'hC8); cyc(2);
    pad(4, 0); cyc(5);
    chk(0, STS, 32'h10, 32'h10, "R5 falling sets");
    cyc(10);
    chk(0, STS, 32'h10, 32'h10, "R7 sticky");
    wr(4, 32'hD8);
    pad(4, 1); cyc(5);
    chk(0, STS, 0, 32'h10, "R5 rising ignored in falling mode");
    // R5 both
    wr(5, 32'hE8); cyc(2);
    pad(5, 1); cyc(5);
    chk(0, STS, 32'h20, 32'h20, "R5 both rise");
    wr(5, 32'hF8);
    pad(5, 0); cyc(5);
    chk(0, STS, 32'h20, 32'h20, "R5 both fall");
    // R9 masking
    chk(1, 0, 1, 1, "R10 irq from pin5");
    wr(5, 32'hE0);
    chk(0, STS, 0, 32'h20, "R9 mask clears");
    cyc(2);
    chk(1, 0, 0, 1, "R10 irq after mask");
    pad(5, 1); cyc(5);
    chk(0, STS, 32'h20, 32'h20, "R10 masked pin pends");
    chk(1, 0, 0, 1, "R10 masked pin no irq");
    wr(5, 32'hE8);
    chk(0, STS, 0, 32'h20, "R9 unmask clears");
    pad(5, 0); cyc(5);
    wr(STS, 32'hFFFFFFFF);
    chk(0, STS, 32'h20, 32'h20, "R7 pending view write ignored");
    wr(5, 32'hF8);
    // R6 level high
    wr(6, 32'h28); cyc(2);
    chk(0, STS, 0, 32'h40, "R6 level high idle");
    pad(6, 1); cyc(5);
    chk(0, STS, 32'h40, 32'h40, "R6 level high sets");
    wr(6, 32'h38); cyc(2);
    chk(0, STS, 32'h40, 32'h40, "R6 level reasserts");
    pad(6, 0); cyc(3);
    wr(6, 32'h38); cyc(3);
    chk(0, STS, 0, 32'h40, "R6 level high released");
    // R6 level low
    wr(7, 32'h48); cyc(3);
    chk(0, STS, 0, 32'h80, "R6 level low idle");
    pad(7, 0); cyc(5);
    chk(0, STS, 32'h80, 32'h80, "R6 level low sets");
    pad(7, 1); cyc(3);
    wr(7, 32'h58); cyc(3);
    chk(0, STS, 0, 32'h80, "R6 level low released");
    // R8 trigger rewrite
    wr(0, 32'hA5);
    chk(0, 0, 0, 32'h4, "R8 oe cleared");
    chk(3, 0, 0, 1, "R8 pad_oe off");
    pad(3, 1); cyc(5);
    chk(0, STS, 32'h08, 32'h08, "R8 setup pin3 pending");
    wr(3, 32'hC8);
    chk(0, STS, 0, 32'h08, "R8 trigger rewrite clears pending");
    // R11 pad disable
    wr(PEN, 32'hF7);
    pad(3, 0); cyc(5);
    chk(0, STS, 0, 32'h08, "R11 disabled pin no event");
    wr(2, 32'h104);
    chk(3, 0, 32'h4, 32'h4, "R11 enabled pin drives");
    wr(PEN, 32'hF3);
    chk(3, 0, 0, 32'h4, "R11 disabled pin no drive");
    cyc(2);
    chk(1, 0, 0, 1, "R10 irq idle at end");
    wait (q.size() == 0);
    cyc(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule